// File: doc/BRIEF.md
# Peripheral Bus Acknowledge Timeout Monitor

This block sits between a host bridge and one peripheral channel bus. When the bridge starts an access (read or write), the monitor waits for the module's active-low acknowledge. A normal access ends when the acknowledge arrives. If it does not arrive within an allowed number of channel clocks, the monitor ends the access itself, so the host is never left waiting. For a read that ends this way, it returns all-ones data. It also latches a bus-error flag for the failed direction.

The allowed wait depends on two things: whether the channel clock runs at its slow rate (8 MHz) or its fast rate (32 MHz), and a short/long timeout select. The limits scale with the clock rate, so the wall-clock timeout stays the same at either rate. The two error flags are cleared by writing one, and their OR is the channel's bus-error interrupt source. A wrapping counter records the accepted acknowledges, and an activity indicator follows the acknowledge pin.

Top module: `bus_ack_watchdog`

## Requirements
- R1: After reset, busy_o, done_o, err_rd_o, err_wr_o and irq_o are 0, ack_cnt_o is 0 and rdata_o is 0.
- R2: A start_i seen while idle begins an access: busy_o is 1 from the next cycle until completion. A start_i seen while busy is ignored.
- R3: If ack_n_i is 0 on a busy cycle whose index k is not above the limit, the access completes. done_o is a one-cycle pulse in the cycle after k, and on a read rdata_o takes the bus_data_i value seen at k.
- R4: The limit in busy cycles is 32 (fast_i=0, long_i=0), 64 (fast_i=0, long_i=1), 128 (fast_i=1, long_i=0) or 256 (fast_i=1, long_i=1). fast_i and long_i are sampled with the start, and later changes do not affect the running access.
- R5: If ack_n_i stays 1 for all limit busy cycles, the access completes with a done_o pulse in the cycle after the last one. A read returns rdata_o all ones.
- R6: A timeout on a read sets err_rd_o and a timeout on a write sets err_wr_o. Both stay set until cleared.
- R7: clr_rd_i clears err_rd_o and clr_wr_i clears err_wr_o on the next cycle. A timeout setting the same flag in that cycle wins over the clear.
- R8: irq_o is 1 exactly when err_rd_o or err_wr_o is 1.
- R9: ack_cnt_o increments by one for each acknowledged access and wraps modulo 2^CNT_W. An acknowledge seen while idle is not counted.
- R10: cnt_clr_i makes ack_cnt_o 0 on the next cycle, even if an acknowledge completes in the same cycle.
- R11: led_o is 1 whenever ack_n_i is 0, busy or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Access start strobe |
| start_rd_i | input | 1 | 1 = read, 0 = write, sampled with start |
| ack_n_i | input | 1 | Module acknowledge, active low |
| bus_data_i | input | DATA_W | Read data from the module |
| fast_i | input | 1 | Clock-rate select, 1 = fast clock |
| long_i | input | 1 | Timeout select, 1 = long limit |
| clr_rd_i | input | 1 | Write-one-to-clear of read error |
| clr_wr_i | input | 1 | Write-one-to-clear of write error |
| cnt_clr_i | input | 1 | Clear the acknowledge counter |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access completion pulse |
| rdata_o | output | DATA_W | Data returned for the last read |
| err_rd_o | output | 1 | Read bus error latched |
| err_wr_o | output | 1 | Write bus error latched |
| irq_o | output | 1 | Bus-error interrupt source |
| ack_cnt_o | output | CNT_W | Acknowledge count |
| led_o | output | 1 | Activity indicator |

## Verification
Accesses are generated at random across all four limit settings. The acknowledge delay is drawn from four classes:
- short delays;
- exactly one cycle before the limit, which must still succeed;
- exactly at the limit, which must time out;
- anything up to a few cycles past the limit.

Comparing the two boundary classes separates an off-by-one in the timeout counter from a correct one. Randomly toggled rate and timeout selects during an access show whether the limit is latched at start. Start strobes pulsed inside an access show whether a second access can sneak in. Directed cases place a clear in the same cycle as a timeout or acknowledge, and an acknowledge while idle. These separate the priority rules from plain set and clear behaviour.

// File: rtl/ackwd_pkg.sv
package ackwd_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ackwd_st_e;

    function automatic int ackwd_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/ackwd_limit_sel.sv
module ackwd_limit_sel #(
    parameter int LIM_W      = 8,
    parameter int SLOW_SHORT = 32,
    parameter int SLOW_LONG  = 64,
    parameter int FAST_SHORT = 128,
    parameter int FAST_LONG  = 256
) (
    input  logic             fast_i,
    input  logic             long_i,
    output logic [LIM_W-1:0] last_o
);
    // Index of the final allowed busy cycle (limit - 1).
    always_comb begin
        unique case ({fast_i, long_i})
            2'b00:   last_o = LIM_W'(SLOW_SHORT - 1);
            2'b01:   last_o = LIM_W'(SLOW_LONG - 1);
            2'b10:   last_o = LIM_W'(FAST_SHORT - 1);
            default: last_o = LIM_W'(FAST_LONG - 1);
        endcase
    end
endmodule

// File: rtl/ackwd_w1c_flag.sv
module ackwd_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    // A hardware set takes priority over a clear in the same cycle.
    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ackwd_ack_counter.sv
module ackwd_ack_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) cnt_d = cnt_q + CNT_W'(1);
        if (clr_i) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/bus_ack_watchdog.sv
module bus_ack_watchdog #(
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 16,
    parameter int SLOW_SHORT = 32,
    parameter int SLOW_LONG  = 64,
    parameter int FAST_SHORT = 128,
    parameter int FAST_LONG  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_rd_i,
    input  logic              ack_n_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              fast_i,
    input  logic              long_i,
    input  logic              clr_rd_i,
    input  logic              clr_wr_i,
    input  logic              cnt_clr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_rd_o,
    output logic              err_wr_o,
    output logic              irq_o,
    output logic [CNT_W-1:0]  ack_cnt_o,
    output logic              led_o
);
    import ackwd_pkg::*;

    localparam int MAX_LIM = ackwd_max4(SLOW_SHORT, SLOW_LONG, FAST_SHORT, FAST_LONG);
    localparam int LIM_W   = (MAX_LIM > 2) ? $clog2(MAX_LIM) : 1;

    typedef struct packed {
        ackwd_st_e         st;
        logic [LIM_W-1:0]  wcnt;
        logic [LIM_W-1:0]  last;
        logic              rd;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ackwd_state_t;

    ackwd_state_t state_d, state_q;
    logic [LIM_W-1:0] sel_last;
    logic acc_ok, acc_to;

    ackwd_limit_sel #(
        .LIM_W(LIM_W), .SLOW_SHORT(SLOW_SHORT), .SLOW_LONG(SLOW_LONG),
        .FAST_SHORT(FAST_SHORT), .FAST_LONG(FAST_LONG)
    ) u_limit (
        .fast_i (fast_i),
        .long_i (long_i),
        .last_o (sel_last)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        acc_ok       = 1'b0;
        acc_to       = 1'b0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    state_d.st   = ST_WAIT;
                    state_d.rd   = start_rd_i;
                    state_d.last = sel_last;
                    state_d.wcnt = '0;
                end
            end
            default: begin
                if (!ack_n_i) begin
                    acc_ok       = 1'b1;
                    state_d.st   = ST_IDLE;
                    state_d.done = 1'b1;
                    if (state_q.rd) state_d.rdata = bus_data_i;
                end else if (state_q.wcnt == state_q.last) begin
                    acc_to       = 1'b1;
                    state_d.st   = ST_IDLE;
                    state_d.done = 1'b1;
                    if (state_q.rd) state_d.rdata = '1;
                end else begin
                    state_d.wcnt = state_q.wcnt + LIM_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.st    <= ST_IDLE;
            state_q.wcnt  <= '0;
            state_q.last  <= '0;
            state_q.rd    <= 1'b0;
            state_q.done  <= 1'b0;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    ackwd_w1c_flag u_err_rd (
        .clk(clk), .rst_n(rst_n),
        .set_i(acc_to & state_q.rd), .clr_i(clr_rd_i), .flag_o(err_rd_o)
    );

    ackwd_w1c_flag u_err_wr (
        .clk(clk), .rst_n(rst_n),
        .set_i(acc_to & ~state_q.rd), .clr_i(clr_wr_i), .flag_o(err_wr_o)
    );

    ackwd_ack_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc_i(acc_ok), .clr_i(cnt_clr_i), .cnt_o(ack_cnt_o)
    );

    assign busy_o  = (state_q.st == ST_WAIT);
    assign done_o  = state_q.done;
    assign rdata_o = state_q.rdata;
    assign irq_o   = err_rd_o | err_wr_o;
    assign led_o   = ~ack_n_i;
endmodule

// File: rtl/bus_ack_watchdog_chk.sv
module bus_ack_watchdog_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              err_rd_o,
    input logic              err_wr_o,
    input logic              cnt_clr_i,
    input logic [CNT_W-1:0]  ack_cnt_o
);
    // R3: completion is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: completion leaves the busy state
    a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5: a new read error comes with completion and all-ones data
    a_r5_rd_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_rd_o) |-> (done_o && (&rdata_o)));

    // R6: a new write error comes with completion
    a_r6_wr_err_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_wr_o) |-> done_o);

    // R10: counter clear takes effect next cycle
    a_r10_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_i |=> (ack_cnt_o == '0));

    // R9: counter moves by at most one per cycle
    a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_i |=> ((ack_cnt_o == $past(ack_cnt_o)) ||
                        (ack_cnt_o == $past(ack_cnt_o) + CNT_W'(1))));
endmodule

bind bus_ack_watchdog bus_ack_watchdog_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .err_rd_o(err_rd_o), .err_wr_o(err_wr_o), .cnt_clr_i(cnt_clr_i), .ack_cnt_o(ack_cnt_o)
);

// File: tb/bus_ack_watchdog_tb.sv
module bus_ack_watchdog_tb;
    localparam int DW = 16;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, start_rd_i = 0, ack_n_i = 1, fast_i = 0, long_i = 0;
    logic clr_rd_i = 0, clr_wr_i = 0, cnt_clr_i = 0;
    logic [DW-1:0] bus_data_i = '0;
    logic busy_o, done_o, err_rd_o, err_wr_o, irq_o, led_o;
    logic [DW-1:0] rdata_o;
    logic [CW-1:0] ack_cnt_o;

    int n_chk = 0, n_fail = 0;
    logic exp_rd = 0, exp_wr = 0;
    logic [CW-1:0] exp_cnt = '0;
    logic [DW-1:0] exp_rdata = '0;

    always #10 clk = ~clk;

    bus_ack_watchdog #(.DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_rd_i(start_rd_i),
        .ack_n_i(ack_n_i), .bus_data_i(bus_data_i), .fast_i(fast_i), .long_i(long_i),
        .clr_rd_i(clr_rd_i), .clr_wr_i(clr_wr_i), .cnt_clr_i(cnt_clr_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .err_rd_o(err_rd_o),
        .err_wr_o(err_wr_o), .irq_o(irq_o), .ack_cnt_o(ack_cnt_o), .led_o(led_o)
    );

    function automatic int limit_of(input logic f, input logic l);
        if (!f) return l ? 64 : 32;
        return l ? 256 : 128;
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_flags();
        chk(err_rd_o == exp_rd, "R6 err_rd", err_rd_o, exp_rd);
        chk(err_wr_o == exp_wr, "R6 err_wr", err_wr_o, exp_wr);
        chk(irq_o == (exp_rd | exp_wr), "R8 irq", irq_o, exp_rd | exp_wr);
        chk(ack_cnt_o == exp_cnt, "R9 ack count", ack_cnt_o, exp_cnt);
    endtask

    // One access: w busy cycles with ack high before ack is driven low.
    task automatic access(input logic rd, input int w, input logic f, input logic l,
                          input logic clr_same, input logic cclr_same);
        int lim, c;
        logic to, early;
        @(negedge clk);
        start_i = 1; start_rd_i = rd; fast_i = f; long_i = l;
        bus_data_i = DW'($urandom);
        lim = limit_of(f, l);
        to = (w >= lim);
        c = to ? lim : w + 1;
        early = 0;
        for (int i = 1; i <= c; i++) begin
            @(negedge clk);
            if (i == 1) chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
            if (done_o) early = 1;
            start_i = 1'($urandom);
            fast_i = 1'($urandom); long_i = 1'($urandom);
            ack_n_i = (!to && i == w + 1) ? 1'b0 : 1'b1;
            clr_rd_i = clr_same && (i == c);
            clr_wr_i = clr_same && (i == c);
            cnt_clr_i = cclr_same && (i == c);
        end
        @(negedge clk);
        start_i = 0; ack_n_i = 1; clr_rd_i = 0; clr_wr_i = 0; cnt_clr_i = 0;
        if (to) begin
            if (rd) begin exp_rd = 1; exp_rdata = '1; end
            else exp_wr = 1;
        end else begin
            exp_cnt = exp_cnt + CW'(1);
            if (rd) exp_rdata = bus_data_i;
        end
        if (clr_same) begin
            exp_rd = to && rd;
            exp_wr = to && !rd;
        end
        if (cclr_same) exp_cnt = '0;
        chk(done_o && !early, to ? "R5 timeout done cycle" : "R3 ack done cycle",
            {early, done_o}, 1);
        chk(!busy_o, "R2 idle after completion", busy_o, 0);
        if (rd) chk(rdata_o == exp_rdata, to ? "R5 rdata ones" : "R3 rdata", rdata_o, exp_rdata);
        chk_flags();
        @(negedge clk);
        chk(!done_o && !busy_o, "R2 start during busy ignored / R3 pulse", {busy_o, done_o}, 0);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_rd_o && !err_wr_o && !irq_o && ack_cnt_o == 0 && rdata_o == 0,
            "R1 reset state", {busy_o, done_o, err_rd_o, err_wr_o, irq_o}, 0);
        rst_n = 1;
        @(negedge clk);

        // R11 / R9: acknowledge while idle lights LED but is not counted
        ack_n_i = 0; #1;
        chk(led_o == 1'b1, "R11 led on ack", led_o, 1);
        @(negedge clk); ack_n_i = 1; #1;
        chk(led_o == 1'b0, "R11 led off", led_o, 0);
        @(negedge clk);
        chk(ack_cnt_o == exp_cnt && !busy_o, "R9 idle ack not counted", ack_cnt_o, exp_cnt);

        // R4 boundaries for each limit, read and write
        for (int s = 0; s < 4; s++) begin
            access(1'b1, limit_of(s[1], s[0]) - 1, s[1], s[0], 0, 0);
            access(1'b0, limit_of(s[1], s[0]), s[1], s[0], 0, 0);
            access(1'b1, limit_of(s[1], s[0]), s[1], s[0], 0, 0);
        end
        // R7: clear wins nothing against a same-cycle timeout set
        access(1'b1, 40, 1'b0, 1'b0, 1, 0);
        access(1'b0, 3, 1'b0, 1'b0, 1, 0);
        // R7 plain clear of both flags
        access(1'b0, 40, 1'b0, 1'b0, 0, 0);
        @(negedge clk); clr_rd_i = 1; clr_wr_i = 1;
        @(negedge clk); clr_rd_i = 0; clr_wr_i = 0; exp_rd = 0; exp_wr = 0;
        chk_flags();
        // R10: counter clear beats a same-cycle acknowledge
        access(1'b1, 2, 1'b1, 1'b0, 0, 1);
        access(1'b0, 0, 1'b1, 1'b1, 0, 0);
        @(negedge clk); cnt_clr_i = 1;
        @(negedge clk); cnt_clr_i = 0; exp_cnt = '0;
        chk(ack_cnt_o == 0, "R10 counter clear", ack_cnt_o, 0);

        // Random mix (also wraps the counter, R9)
        for (int k = 0; k < 60; k++) begin
            logic f, l, r;
            int lim, w;
            f = 1'($urandom); l = 1'($urandom); r = 1'($urandom);
            lim = limit_of(f, l);
            case ($urandom % 4)
                0: w = $urandom % 8;
                1: w = lim - 1;
                2: w = lim;
                default: w = $urandom % (lim + 4);
            endcase
            access(r, w, f, l, ($urandom % 8) == 0, ($urandom % 10) == 0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule